// File: doc/BRIEF.md
# Dual-Field Multiply-Accumulate Unit

This unit performs one step of a word-serial multiple-precision multiplication. Each issued operation multiplies two 64-bit operands and adds a third 64-bit operand. The multiplication is done either as an ordinary unsigned integer multiply or as a carry-less multiply of binary polynomials, where addition is bitwise XOR. The step can also fold in a 64-bit extended carry that the unit keeps internally. The 128-bit total splits in two. The low half is returned as the result, and the high half is stored as the new extended carry, ready for the next chained step.

One reduction structure produces both products. The partial products are first combined with XOR cells only, which gives the carry-less product directly. The carry terms from those cells are collected separately and added back only to form the integer product. An operation is accepted on a cycle with `in_valid` high, and its result appears with `out_valid` one clock later.

Top module: `dfmac_unit`

## Requirements
- R1: With `field_bin`=0 and `use_carry`=0, `result` equals bits 63:0 of op_a*op_b+op_c, computed as unsigned integers.
- R2: In integer mode, bits 127:64 of the 128-bit sum become the new extended carry.
- R3: With `field_bin`=0 and `use_carry`=1, the extended carry is added as a 64-bit value at bit 0, so the sum is op_a*op_b+op_c+XC.
- R4: With `field_bin`=1 and `use_carry`=0, `result` equals bits 63:0 of clmul(op_a,op_b) XOR op_c. Here clmul is the carry-less polynomial product.
- R5: In binary mode, bits 127:64 of the XOR sum become the new extended carry.
- R6: With `field_bin`=1 and `use_carry`=1, the extended carry is XORed into bits 63:0 before the sum is split.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `result` holds that operation's value in the same cycle.
- R8: Synchronous reset clears the extended carry to zero and drives `out_valid` low.
- R9: Cycles with `in_valid` low leave the extended carry unchanged.
- R10: With `use_carry`=0 the stored extended carry has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue an operation this cycle |
| field_bin | input | 1 | 0: integer, 1: binary polynomial (carry-less) |
| use_carry | input | 1 | Fold the stored extended carry into the sum |
| op_a | input | 64 | Multiplicand |
| op_b | input | 64 | Multiplier |
| op_c | input | 64 | Accumulate operand |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| result | output | 64 | Low word of the sum |

## Verification
The extended carry can only be observed through the ports. The bench reads it with a readout operation that has zero operands and `use_carry`=1, which returns the stored carry unchanged in either mode.

The bench runs several operand sets:
- Walking single-bit operands isolate each partial-product row and shift position.
- All-ones operands stress the carry path, because the integer and carry-less products differ most there.
- Randomly chosen operands, modes and carry flags in long chains show that the high word carries correctly from one step to the next.

Runs with a nonzero stored carry and `use_carry`=0, and runs with idle gaps, separate R10 and R9 from the plain arithmetic checks.

// File: rtl/dfmac_pkg.sv
package dfmac_pkg;

    typedef enum logic {
        FLD_INT = 1'b0,
        FLD_BIN = 1'b1
    } field_e;

endpackage

// File: rtl/dfmac_pprod.sv
// Partial-product reduction shared by both fields. Rows are combined with
// XOR (sum outputs) first; carry terms are collected on a separate vector
// and added back only for the integer product.
module dfmac_pprod #(
    parameter int W = 64
) (
    input  logic [W-1:0]   mul_a,
    input  logic [W-1:0]   mul_b,
    output logic [2*W-1:0] prod_xor,
    output logic [2*W-1:0] prod_int
);
    localparam int PW = 2 * W;

    logic [PW-1:0] sum_acc;
    logic [PW-1:0] cry_acc;
    logic [PW-1:0] row;

    always_comb begin
        sum_acc = '0;
        cry_acc = '0;
        row     = '0;
        for (int k = 0; k < W; k++) begin
            row     = mul_b[k] ? ({{W{1'b0}}, mul_a} << k) : '0;
            cry_acc = cry_acc + ((sum_acc & row) << 1);
            sum_acc = sum_acc ^ row;
        end
        prod_xor = sum_acc;
        prod_int = sum_acc + cry_acc;
    end

endmodule

// File: rtl/dfmac_accum.sv
// Adds the accumulate operand and optional extended carry in the chosen field.
module dfmac_accum
    import dfmac_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [2*W-1:0] prod_xor,
    input  logic [2*W-1:0] prod_int,
    input  logic [W-1:0]   acc_c,
    input  logic [W-1:0]   xc_in,
    input  field_e         field,
    input  logic           carry_en,
    output logic [2*W-1:0] total
);
    logic [2*W-1:0] c_ext;
    logic [2*W-1:0] xc_ext;

    always_comb begin
        c_ext  = {{W{1'b0}}, acc_c};
        xc_ext = carry_en ? {{W{1'b0}}, xc_in} : '0;
        if (field == FLD_BIN) begin
            total = prod_xor ^ c_ext ^ xc_ext;
        end else begin
            total = prod_int + c_ext + xc_ext;
        end
    end

endmodule

// File: rtl/dfmac_unit.sv
module dfmac_unit
    import dfmac_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         field_bin,
    input  logic         use_carry,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    output logic         out_valid,
    output logic [W-1:0] result
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic [W-1:0] xc;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [PW-1:0] p_xor;
    logic [PW-1:0] p_int;
    logic [PW-1:0] sum_w;
    field_e        fsel;

    assign fsel = field_e'(field_bin);

    dfmac_pprod #(.W(W)) u_pprod (
        .mul_a    (op_a),
        .mul_b    (op_b),
        .prod_xor (p_xor),
        .prod_int (p_int)
    );

    dfmac_accum #(.W(W)) u_accum (
        .prod_xor (p_xor),
        .prod_int (p_int),
        .acc_c    (op_c),
        .xc_in    (st_q.xc),
        .field    (fsel),
        .carry_en (use_carry),
        .total    (sum_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = sum_w[W-1:0];
            st_d.xc  = sum_w[PW-1:W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_XC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(st_q.xc)); // R9
    AST_ZERO_MULT_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_b == '0 && !use_carry) |=> (result == $past(op_c))); // R10
    AST_LSB_FIELDS_AGREE: assert property (@(posedge clk) disable iff (rst)
        p_int[0] == p_xor[0]); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && st_q.xc == '0)); // R8

endmodule

// File: tb/sim_dfmac_unit.sv
module sim_dfmac_unit;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         field_bin;
    logic         use_carry;
    logic [W-1:0] op_a, op_b, op_c;
    logic         out_valid;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] xc_m;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dfmac_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .field_bin(field_bin),
        .use_carry(use_carry), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] clmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] acc = '0;
        for (int i = 0; i < 64; i++)
            if (b[i]) acc = acc ^ ({64'd0, a} << i);
        return acc;
    endfunction

    function automatic logic [127:0] model(input bit fb, input bit uc,
            input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
            input logic [63:0] xc);
        logic [127:0] xe = uc ? {64'd0, xc} : 128'd0;
        if (fb) return clmul(a, b) ^ {64'd0, c} ^ xe;
        return ({64'd0, a} * {64'd0, b}) + {64'd0, c} + xe;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input string req, input bit fb, input bit uc,
            input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
        logic [127:0] s = model(fb, uc, a, b, c, xc_m);
        @(negedge clk);
        in_valid = 1'b1; field_bin = fb; use_carry = uc;
        op_a = a; op_b = b; op_c = c;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid R7"}, {63'd0, out_valid}, 64'd1);
        check(req, result, s[63:0]);
        xc_m = s[127:64];
    endtask

    // Readout: zero operands with carry returns stored extended carry (R2/R5)
    task automatic readout(input string req, input bit fb);
        op(req, fb, 1'b1, 64'd0, 64'd0, 64'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected < 150000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; field_bin = 1'b0; use_carry = 1'b0;
        op_a = '0; op_b = '0; op_c = '0; xc_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8 out_valid after reset", {63'd0, out_valid}, 64'd0);
        readout("R8 xc cleared", 1'b0);

        // R1/R4 walking single bits
        for (int i = 0; i < 64; i++) begin
            op("R1 walk", 1'b0, 1'b0, 64'd1 << i, 64'h8000_0000_0000_0001, 64'd3);
            readout("R2 walk", 1'b0);
            op("R4 walk", 1'b1, 1'b0, 64'h8000_0000_0000_0001, 64'd1 << i, 64'd5);
            readout("R5 walk", 1'b1);
        end

        // all-ones: integer vs carry-less differ strongly
        op("R1 ones", 1'b0, 1'b0, '1, '1, '1);
        readout("R2 ones", 1'b0);
        op("R4 ones", 1'b1, 1'b0, '1, '1, '1);
        readout("R5 ones", 1'b1);

        // R3 chained integer carry
        op("R1 chain start", 1'b0, 1'b0, '1, '1, '1);
        op("R3 chain", 1'b0, 1'b1, '1, '1, '1);
        op("R3 chain", 1'b0, 1'b1, 64'h1234_5678_9abc_def0, '1, '1);
        readout("R2 after chain", 1'b0);

        // R6 chained binary carry
        op("R4 chain start", 1'b1, 1'b0, '1, 64'hdead_beef_0bad_f00d, 64'd7);
        op("R6 chain", 1'b1, 1'b1, 64'hcafe_0000_1111_2222, '1, 64'd9);
        readout("R5 after chain", 1'b1);

        // R10: nonzero stored carry ignored without use_carry
        op("R10 setup", 1'b0, 1'b0, '1, '1, 64'd0);
        op("R10 int ignore", 1'b0, 1'b0, 64'd2, 64'd3, 64'd4);
        op("R10 setup", 1'b1, 1'b0, '1, '1, 64'd0);
        op("R10 bin ignore", 1'b1, 1'b0, 64'd6, 64'd3, 64'd0);

        // R9 idle gap with changing inputs keeps carry
        op("R9 setup", 1'b0, 1'b0, '1, 64'hffff, 64'd0);
        for (int g = 0; g < 5; g++) begin
            @(negedge clk);
            op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
            use_carry = 1'b1; field_bin = g[0];
            check("R7 idle no valid", {63'd0, out_valid}, 64'd0);
        end
        readout("R9 xc held", 1'b0);

        // random chains over modes and carry flags
        for (int n = 0; n < 600; n++) begin
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            logic [63:0] rc = {$urandom, $urandom};
            bit fb = $urandom_range(0, 1) == 1;
            bit uc = $urandom_range(0, 1) == 1;
            op(fb ? (uc ? "R6 rand" : "R4 rand") : (uc ? "R3 rand" : "R1 rand"),
               fb, uc, ra, rb, rc);
            if (n % 7 == 0) readout(fb ? "R5 rand" : "R2 rand", fb);
        end

        // R8 reset mid-stream clears carry
        op("R8 setup", 1'b0, 1'b0, '1, '1, '1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 valid low", {63'd0, out_valid}, 64'd0);
        xc_m = '0;
        readout("R8 xc zero", 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule